// File: doc/BRIEF.md
# Host Memory Window

This block gives a host controlled, bounded access to a local SRAM through a small register pair: an index register and a data register. The index names one of two windows and a byte offset inside it; every access through the data register is turned into an SRAM bus cycle at the window base plus that offset, provided the offset lies below the limit that applies to the direction of the access. After each data access the offset advances by the access size, so a host can stream through a window without rewriting the index.

Each window is configured from the local side with a base address and a 32-bit limit word holding a separate read limit and write limit. The two limits together carve a window into sub-ranges: both zero disables it, one of them zero makes it read-only or write-only, and unequal non-zero limits give a read/write lower part with a read-only or write-only upper part. Blocked reads answer zero and blocked writes vanish without touching the SRAM.

The host side is a one-request-at-a-time register bus with 8-, 16- and 32-bit accesses; the SRAM side is a 32-bit request/ready port with byte enables.

Top module: `host_mem_window`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `host_ack` and `sram_req` are low; after reset the index register reads 0 and both windows have base 0 and limit word 0.
- R2: With `host_reg`=0 (index register) a host write loads the offset from `host_wdata[14:0]` and the window select from `host_wdata[15]`; a host read returns `{16'b0, select, offset}` in `host_rdata`, with `host_ack` high in the cycle after the request.
- R3: Window base bits [1:0] are ignored: the SRAM byte address of a permitted access is (base with bits [1:0] cleared) plus the current offset.
- R4: The limit word holds the read limit in bits [15:0] and the write limit in bits [31:16]; bits [1:0] of each limit are ignored. A data read is permitted only when offset bits [14:2] are below read-limit bits [15:2], a data write only when they are below write-limit bits [15:2].
- R5: A window whose limit word is zero blocks every data access.
- R6: A read-only window (write limit 0) blocks writes; a write-only window (read limit 0) blocks reads; with write limit below read limit the band between them is readable but not writable, and with read limit below write limit it is writable but not readable.
- R7: A blocked data access issues no SRAM request and raises `host_ack` in the cycle after the request; a blocked read returns 0 in `host_rdata`.
- R8: Each data access (`host_reg`=1) advances the offset by its size in bytes (`host_size` 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes), whether permitted or blocked, modulo 2^15, with the window select unchanged.
- R9: Byte lanes follow the offset: a byte access enables lane offset[1:0] and a halfword lanes {1,0} or {3,2} by offset[1]; write data is taken from the low bits of `host_wdata` and moved to the enabled lanes, read data is returned right-aligned and zero-extended.
- R10: A permitted access raises `sram_req` in the cycle after the request and holds it, with address, byte enables and direction stable, until `sram_rdy` is seen high; `host_ack` rises in the cycle after that and is a single-cycle pulse.
- R11: Index bit 15 selects which window's base and limits apply; local-side writes with `cfg_field`=0 load the base and with `cfg_field`=1 load the limit word of window `cfg_win`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Single-cycle host request strobe |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_reg | input | 1 | 0 = index register, 1 = data register |
| host_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| host_wdata | input | 32 | Host write data |
| host_ack | output | 1 | Completion pulse |
| host_rdata | output | 32 | Read result, valid with host_ack |
| cfg_we | input | 1 | Local configuration write strobe |
| cfg_win | input | 1 | Window being configured |
| cfg_field | input | 1 | 0 = base, 1 = limit word |
| cfg_data | input | 32 | Configuration value |
| sram_req | output | 1 | SRAM bus cycle request |
| sram_we | output | 1 | SRAM write when high |
| sram_addr | output | 32 | SRAM byte address |
| sram_be | output | 4 | SRAM byte enables |
| sram_wdata | output | 32 | SRAM write data, lane-aligned |
| sram_rdata | input | 32 | SRAM read data |
| sram_rdy | input | 1 | SRAM completes the request |

## Verification
The assertions take for granted that the host issues one request and then waits for its acknowledge before the next, that `host_req` is a single-cycle pulse, and that window configuration does not change while an SRAM cycle is pending. The stimulus keeps within this by driving every host access through one task that pulses the request, serves the SRAM side itself with a chosen number of wait cycles and returns only after the acknowledge, and by writing configuration only between host accesses.

// File: rtl/hmw_pkg.sv
package hmw_pkg;

    localparam int DW    = 32;
    localparam int NLANE = DW / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic {
        REG_INDEX = 1'b0,
        REG_DATA  = 1'b1
    } host_reg_e;

    typedef enum logic {
        CFG_BASE  = 1'b0,
        CFG_LIMIT = 1'b1
    } cfg_field_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } bus_state_e;

    // Packed limit word: write limit in the upper half, read limit in the lower.
    typedef struct packed {
        logic [15:0] wr_lim;
        logic [15:0] rd_lim;
    } limit_word_t;

    // Captured description of one SRAM bus cycle.
    typedef struct packed {
        logic             we;
        logic [1:0]       lo;
        logic [1:0]       size;
        logic [NLANE-1:0] be;
        logic [DW-1:0]    wdata;
    } bus_cycle_t;

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [NLANE-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] lo);
        case (sz)
            SZ_BYTE: return 4'b0001 << lo;
            SZ_HALF: return lo[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [DW-1:0] lane_fill(input logic [1:0] sz, input logic [1:0] lo,
                                                input logic [DW-1:0] d);
        case (sz)
            SZ_BYTE: return {24'b0, d[7:0]} << {lo, 3'b000};
            SZ_HALF: return {16'b0, d[15:0]} << {lo[1], 4'b0000};
            default: return d;
        endcase
    endfunction

    function automatic logic [DW-1:0] lane_pick(input logic [1:0] sz, input logic [1:0] lo,
                                                input logic [DW-1:0] d);
        logic [DW-1:0] s;
        case (sz)
            SZ_BYTE: begin
                s = d >> {lo, 3'b000};
                return {24'b0, s[7:0]};
            end
            SZ_HALF: begin
                s = d >> {lo[1], 4'b0000};
                return {16'b0, s[15:0]};
            end
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/hmw_window_bank.sv
module hmw_window_bank
    import hmw_pkg::*;
#(
    parameter int NWIN = 2,
    parameter int AW   = 32,
    localparam int WSEL_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [WSEL_W-1:0] cfg_win,
    input  logic              cfg_field,
    input  logic [31:0]       cfg_data,
    input  logic [WSEL_W-1:0] sel,
    output logic [AW-1:0]     sel_base,
    output limit_word_t       sel_lim
);

    logic [AW-1:0] base_vec [NWIN];
    limit_word_t   lim_vec  [NWIN];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic [AW-1:0] base_q;
        limit_word_t   lim_q;
        logic          hit;

        assign hit = cfg_we && (cfg_win == WSEL_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                base_q <= '0;
                lim_q  <= '0;
            end else if (hit) begin
                if (cfg_field == CFG_BASE) begin
                    base_q <= {cfg_data[AW-1:2], 2'b00};
                end else begin
                    lim_q <= limit_word_t'(cfg_data);
                end
            end
        end

        assign base_vec[w] = base_q;
        assign lim_vec[w]  = lim_q;
    end

    always_comb begin
        sel_base = '0;
        sel_lim  = '0;
        for (int w = 0; w < NWIN; w++) begin
            if (sel == WSEL_W'(w)) begin
                sel_base = base_vec[w];
                sel_lim  = lim_vec[w];
            end
        end
    end

endmodule

// File: rtl/hmw_index.sv
module hmw_index #(
    parameter int OFS_W  = 15,
    parameter int WSEL_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [31:0]       ld_data,
    input  logic              adv,
    input  logic [2:0]        adv_bytes,
    output logic [OFS_W-1:0]  ofs,
    output logic [WSEL_W-1:0] win
);

    localparam int TOP = OFS_W + WSEL_W;

    logic unused_ld_hi;
    assign unused_ld_hi = ^ld_data[31:TOP];

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs <= '0;
            win <= '0;
        end else if (ld) begin
            ofs <= ld_data[OFS_W-1:0];
            win <= ld_data[TOP-1:OFS_W];
        end else if (adv) begin
            ofs <= ofs + OFS_W'(adv_bytes);
        end
    end

endmodule

// File: rtl/hmw_limit_check.sv
module hmw_limit_check
    import hmw_pkg::*;
#(
    parameter int OFS_W = 15,
    localparam int CW = 14
) (
    input  logic [OFS_W-1:0] ofs,
    input  limit_word_t      lim,
    input  logic             is_write,
    output logic             allowed
);

    logic [CW-1:0] ofs_word;
    logic [CW-1:0] rd_word;
    logic [CW-1:0] wr_word;
    logic          rd_ok;
    logic          wr_ok;
    logic          unused_low;

    // Comparison is done at 32-bit word granularity.
    assign ofs_word   = CW'(ofs[OFS_W-1:2]);
    assign rd_word    = lim.rd_lim[15:2];
    assign wr_word    = lim.wr_lim[15:2];
    assign unused_low = ^{ofs[1:0], lim.rd_lim[1:0], lim.wr_lim[1:0]};

    assign rd_ok   = ofs_word < rd_word;
    assign wr_ok   = ofs_word < wr_word;
    assign allowed = is_write ? wr_ok : rd_ok;

endmodule

// File: rtl/host_mem_window.sv
module host_mem_window
    import hmw_pkg::*;
#(
    parameter int NWIN  = 2,
    parameter int OFS_W = 15,
    parameter int AW    = 32,
    localparam int WSEL_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_reg,
    input  logic [1:0]        host_size,
    input  logic [31:0]       host_wdata,
    output logic              host_ack,
    output logic [31:0]       host_rdata,
    input  logic              cfg_we,
    input  logic [WSEL_W-1:0] cfg_win,
    input  logic              cfg_field,
    input  logic [31:0]       cfg_data,
    output logic              sram_req,
    output logic              sram_we,
    output logic [AW-1:0]     sram_addr,
    output logic [3:0]        sram_be,
    output logic [31:0]       sram_wdata,
    input  logic [31:0]       sram_rdata,
    input  logic              sram_rdy
);

    bus_state_e        st_q;
    bus_cycle_t        cyc_q;
    logic              accept;
    logic              is_data;
    logic              allowed;
    logic [OFS_W-1:0]  idx_ofs;
    logic [WSEL_W-1:0] idx_win;
    logic [AW-1:0]     sel_base;
    limit_word_t       sel_lim;
    logic              idx_ld;
    logic              idx_adv;
    logic [31:0]       idx_readback;

    assign accept       = host_req && (st_q == ST_IDLE) && !host_ack;
    assign is_data      = (host_reg == REG_DATA);
    assign idx_ld       = accept && !is_data && host_we;
    assign idx_adv      = accept && is_data;
    assign idx_readback = 32'({idx_win, idx_ofs});

    hmw_window_bank #(.NWIN(NWIN), .AW(AW)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_win  (cfg_win),
        .cfg_field(cfg_field),
        .cfg_data (cfg_data),
        .sel      (idx_win),
        .sel_base (sel_base),
        .sel_lim  (sel_lim)
    );

    hmw_index #(.OFS_W(OFS_W), .WSEL_W(WSEL_W)) u_index (
        .clk      (clk),
        .rst      (rst),
        .ld       (idx_ld),
        .ld_data  (host_wdata),
        .adv      (idx_adv),
        .adv_bytes(size_bytes(host_size)),
        .ofs      (idx_ofs),
        .win      (idx_win)
    );

    hmw_limit_check #(.OFS_W(OFS_W)) u_check (
        .ofs     (idx_ofs),
        .lim     (sel_lim),
        .is_write(host_we),
        .allowed (allowed)
    );

    assign sram_we    = cyc_q.we;
    assign sram_be    = cyc_q.be;
    assign sram_wdata = cyc_q.wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            cyc_q      <= '0;
            sram_req   <= 1'b0;
            sram_addr  <= '0;
            host_ack   <= 1'b0;
            host_rdata <= '0;
        end else begin
            host_ack <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (!is_data) begin
                            host_ack <= 1'b1;
                            if (!host_we) begin
                                host_rdata <= idx_readback;
                            end
                        end else if (!allowed) begin
                            host_ack <= 1'b1;
                            if (!host_we) begin
                                host_rdata <= '0;
                            end
                        end else begin
                            st_q        <= ST_BUS;
                            sram_req    <= 1'b1;
                            sram_addr   <= sel_base + AW'(idx_ofs);
                            cyc_q.we    <= host_we;
                            cyc_q.lo    <= idx_ofs[1:0];
                            cyc_q.size  <= host_size;
                            cyc_q.be    <= lane_mask(host_size, idx_ofs[1:0]);
                            cyc_q.wdata <= lane_fill(host_size, idx_ofs[1:0], host_wdata);
                        end
                    end
                end
                ST_BUS: begin
                    if (sram_rdy) begin
                        st_q     <= ST_IDLE;
                        sram_req <= 1'b0;
                        host_ack <= 1'b1;
                        if (!cyc_q.we) begin
                            host_rdata <= lane_pick(cyc_q.size, cyc_q.lo, sram_rdata);
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hmw_chk.sv
module hmw_chk
    import hmw_pkg::*;
#(
    parameter int OFS_W = 15,
    parameter int AW    = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             host_we,
    input logic [1:0]       host_size,
    input logic             host_ack,
    input logic [31:0]      host_rdata,
    input logic             sram_req,
    input logic             sram_rdy,
    input logic             sram_we,
    input logic [AW-1:0]    sram_addr,
    input logic [3:0]       sram_be,
    input logic             accept,
    input logic             is_data,
    input logic             allowed,
    input limit_word_t      sel_lim,
    input logic [OFS_W-1:0] idx_ofs
);

    logic [OFS_W-1:0] step;
    always_comb begin
        case (host_size)
            2'd0:    step = OFS_W'(1);
            2'd1:    step = OFS_W'(2);
            default: step = OFS_W'(4);
        endcase
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!host_ack && !sram_req)); // R1

    AST_DISABLED_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (accept && is_data && (sel_lim == '0)) |-> !allowed); // R5

    AST_BLOCKED_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        (accept && is_data && !allowed) |=> (host_ack && !sram_req)); // R7

    AST_BLOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (accept && is_data && !allowed && !host_we) |=> (host_rdata == 32'd0)); // R7

    AST_INDEX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (accept && is_data) |=> (idx_ofs == $past(idx_ofs) + $past(step))); // R8

    AST_LANES_ENABLED: assert property (@(posedge clk) disable iff (rst)
        sram_req |-> (sram_be != 4'd0)); // R9

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (sram_req && !sram_rdy) |=> (sram_req && $stable(sram_addr) && $stable(sram_be) && $stable(sram_we))); // R10

    AST_ACK_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        (sram_req && sram_rdy) |=> (host_ack && !sram_req)); // R10

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack); // R10

endmodule

bind host_mem_window hmw_chk #(.OFS_W(OFS_W), .AW(AW)) u_hmw_chk (
    .clk       (clk),
    .rst       (rst),
    .host_we   (host_we),
    .host_size (host_size),
    .host_ack  (host_ack),
    .host_rdata(host_rdata),
    .sram_req  (sram_req),
    .sram_rdy  (sram_rdy),
    .sram_we   (sram_we),
    .sram_addr (sram_addr),
    .sram_be   (sram_be),
    .accept    (accept),
    .is_data   (is_data),
    .allowed   (allowed),
    .sel_lim   (sel_lim),
    .idx_ofs   (idx_ofs)
);

// File: tb/test_host_mem_window.sv
module test_host_mem_window;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic        host_reg = 1'b0;
    logic [1:0]  host_size = 2'd0;
    logic [31:0] host_wdata = '0;
    logic        host_ack;
    logic [31:0] host_rdata;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_win = 1'b0;
    logic        cfg_field = 1'b0;
    logic [31:0] cfg_data = '0;
    logic        sram_req;
    logic        sram_we;
    logic [31:0] sram_addr;
    logic [3:0]  sram_be;
    logic [31:0] sram_wdata;
    logic [31:0] sram_rdata = '0;
    logic        sram_rdy = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference model state
    logic [31:0] m_base [2];
    logic [31:0] m_lim  [2];
    int          m_ofs = 0;
    int          m_win = 0;
    logic [31:0] mem [int];

    always #4 clk = ~clk;

    host_mem_window i_host_mem_window (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_we(host_we), .host_reg(host_reg),
        .host_size(host_size), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata),
        .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_field(cfg_field), .cfg_data(cfg_data),
        .sram_req(sram_req), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_be(sram_be), .sram_wdata(sram_wdata),
        .sram_rdata(sram_rdata), .sram_rdy(sram_rdy)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_get(input int w);
        if (mem.exists(w)) return mem[w];
        return 32'hC0DE0000 ^ 32'(w);
    endfunction

    function automatic logic [31:0] be_mask(input logic [3:0] be);
        logic [31:0] m = '0;
        for (int b = 0; b < 4; b++) if (be[b]) m[8*b +: 8] = 8'hFF;
        return m;
    endfunction

    // One host transaction; serves the SRAM side when a bus cycle appears.
    task automatic host_op(input bit reg_sel, input bit we, input logic [1:0] sz,
                           input logic [31:0] wd, input int waitc, input string req,
                           output logic [31:0] rd, output bit bus,
                           output logic [31:0] c_addr, output logic [3:0] c_be,
                           output logic [31:0] c_wd);
        @(negedge clk);
        host_req = 1'b1; host_reg = reg_sel; host_we = we; host_size = sz; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        bus = sram_req;
        c_addr = sram_addr; c_be = sram_be; c_wd = sram_wdata;
        if (bus) begin
            check(req, "SRAM direction", 32'(sram_we), 32'(we));
            for (int i = 0; i < waitc; i++) begin
                check("R10", "request held while waiting", 32'(sram_req), 32'd1);
                check("R10", "address stable while waiting", sram_addr, c_addr);
                check("R10", "no early ack", 32'(host_ack), 32'd0);
                @(negedge clk);
            end
            sram_rdy = 1'b1;
            sram_rdata = mem_get(int'(c_addr >> 2));
            if (we) begin
                logic [31:0] cur;
                cur = mem_get(int'(c_addr >> 2));
                mem[int'(c_addr >> 2)] = (cur & ~be_mask(c_be)) | (c_wd & be_mask(c_be));
            end
            @(negedge clk);
            sram_rdy = 1'b0;
            check("R10", "request dropped after ready", 32'(sram_req), 32'd0);
        end
        check(req, "host_ack pulse", 32'(host_ack), 32'd1);
        rd = host_rdata;
        @(negedge clk);
        check("R10", "ack lasts one cycle", 32'(host_ack), 32'd0);
    endtask

    task automatic idx_write(input logic [31:0] v);
        logic [31:0] rd, a, w; logic [3:0] b; bit bus;
        host_op(1'b0, 1'b1, 2'd2, v, 0, "R2", rd, bus, a, b, w);
        m_ofs = int'(v & 32'h7FFF);
        m_win = int'((v >> 15) & 1);
    endtask

    task automatic idx_check(input string req);
        logic [31:0] rd, a, w; logic [3:0] b; bit bus;
        host_op(1'b0, 1'b0, 2'd2, 32'h0, 0, req, rd, bus, a, b, w);
        check(req, "index readback", rd, 32'((m_win << 15) | m_ofs));
    endtask

    task automatic cfg(input int win, input bit field, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = 1'(win); cfg_field = field; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (field) m_lim[win] = d; else m_base[win] = d & ~32'h3;
    endtask

    task automatic data_op(input bit we, input logic [1:0] sz, input logic [31:0] wd,
                           input int waitc, input string req);
        logic [31:0] lim, exp_addr, cur, exp_rd, exp_wd, rd, c_addr, c_wd;
        logic [3:0]  exp_be, c_be;
        bit ok, bus;
        int lo, nb;
        lim = m_lim[m_win];
        lo  = m_ofs & 3;
        if (we) ok = (32'(m_ofs >> 2) < ((lim >> 16) >> 2));
        else    ok = (32'(m_ofs >> 2) < ((lim & 32'hFFFF) >> 2));
        exp_addr = m_base[m_win] + 32'(m_ofs);
        cur = mem_get(int'(exp_addr >> 2));
        case (sz)
            2'd0: begin
                nb = 1; exp_be = 4'b0001 << lo;
                exp_wd = {24'b0, wd[7:0]} << (8 * lo);
                exp_rd = (cur >> (8 * lo)) & 32'hFF;
            end
            2'd1: begin
                nb = 2; exp_be = (lo >= 2) ? 4'b1100 : 4'b0011;
                exp_wd = {16'b0, wd[15:0]} << (16 * (lo / 2));
                exp_rd = (cur >> (16 * (lo / 2))) & 32'hFFFF;
            end
            default: begin
                nb = 4; exp_be = 4'b1111; exp_wd = wd; exp_rd = cur;
            end
        endcase
        if (!ok) exp_rd = 32'd0;
        host_op(1'b1, we, sz, wd, waitc, req, rd, bus, c_addr, c_be, c_wd);
        check(req, "bus cycle issued only when permitted", 32'(bus), 32'(ok));
        if (bus && ok) begin
            check("R3", "SRAM address", c_addr, exp_addr);
            check("R9", "byte enables", 32'(c_be), 32'(exp_be));
            if (we) check("R9", "lane write data", c_wd & be_mask(exp_be), exp_wd & be_mask(exp_be));
        end
        if (!we) check(ok ? req : "R7", "read data", rd, exp_rd);
        m_ofs = (m_ofs + nb) & 32'h7FFF;
    endtask

    initial begin
        m_base[0] = '0; m_base[1] = '0; m_lim[0] = '0; m_lim[1] = '0;
        repeat (3) @(negedge clk);
        check("R1", "host_ack in reset", 32'(host_ack), 32'd0);
        check("R1", "sram_req in reset", 32'(sram_req), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "host_ack after reset", 32'(host_ack), 32'd0);
        check("R1", "sram_req after reset", 32'(sram_req), 32'd0);
        idx_check("R1");

        // R5: disabled window after reset
        data_op(1'b0, 2'd2, 32'h0, 0, "R5");
        data_op(1'b1, 2'd2, 32'h12345678, 0, "R5");
        idx_check("R8");

        // R2: index layout
        idx_write(32'h0000_8004);
        idx_check("R2");

        // R3/R4/R6: window 0, write limit below read limit
        cfg(0, 1'b0, 32'h0000_1003);
        cfg(0, 1'b1, 32'h0020_0040);
        idx_write(32'h001C);
        data_op(1'b1, 2'd2, 32'hDEADBEEF, 0, "R4");
        data_op(1'b1, 2'd2, 32'h11111111, 0, "R6");
        idx_write(32'h001C);
        data_op(1'b0, 2'd2, 32'h0, 0, "R3");
        data_op(1'b0, 2'd2, 32'h0, 0, "R6");
        idx_write(32'h003C);
        data_op(1'b0, 2'd2, 32'h0, 0, "R4");
        data_op(1'b0, 2'd2, 32'h0, 0, "R4");

        // R11: window 1 read-only
        cfg(1, 1'b0, 32'h0000_2000);
        cfg(1, 1'b1, 32'h0000_0010);
        idx_write(32'h8000);
        data_op(1'b1, 2'd2, 32'h55AA55AA, 0, "R6");
        idx_write(32'h8000);
        data_op(1'b0, 2'd2, 32'h0, 0, "R11");

        // R6/R7: write-only
        cfg(1, 1'b1, 32'h0010_0000);
        idx_write(32'h8000);
        data_op(1'b0, 2'd2, 32'h0, 0, "R7");
        idx_write(32'h8000);
        data_op(1'b1, 2'd2, 32'hCAFEF00D, 0, "R6");

        // R6: read limit below write limit
        cfg(1, 1'b1, 32'h0010_0008);
        idx_write(32'h8008);
        data_op(1'b0, 2'd2, 32'h0, 0, "R6");
        idx_write(32'h8008);
        data_op(1'b1, 2'd2, 32'h0BADC0DE, 0, "R6");

        // R4: low limit bits ignored
        cfg(1, 1'b1, 32'h0000_0007);
        idx_write(32'h8000);
        data_op(1'b0, 2'd2, 32'h0, 0, "R4");
        data_op(1'b0, 2'd2, 32'h0, 0, "R4");

        // R9/R8: byte and halfword lanes in window 0
        idx_write(32'h0000);
        data_op(1'b1, 2'd0, 32'h11, 0, "R9");
        data_op(1'b1, 2'd0, 32'hFF22, 0, "R9");
        data_op(1'b1, 2'd0, 32'h33, 0, "R9");
        data_op(1'b1, 2'd0, 32'h44, 0, "R9");
        idx_check("R8");
        idx_write(32'h0000);
        data_op(1'b0, 2'd2, 32'h0, 0, "R9");
        idx_write(32'h0000);
        data_op(1'b0, 2'd1, 32'h0, 0, "R9");
        data_op(1'b0, 2'd1, 32'h0, 0, "R9");
        idx_write(32'h0003);
        data_op(1'b0, 2'd0, 32'h0, 0, "R9");
        idx_write(32'h0002);
        data_op(1'b1, 2'd1, 32'hFFFFABCD, 0, "R9");
        idx_write(32'h0000);
        data_op(1'b0, 2'd2, 32'h0, 0, "R9");

        // R10: wait states
        idx_write(32'h0010);
        data_op(1'b1, 2'd2, 32'h600DF00D, 3, "R10");
        idx_write(32'h0010);
        data_op(1'b0, 2'd2, 32'h0, 2, "R10");

        // R8: wrap within 15 bits, select kept
        cfg(1, 1'b1, 32'h0);
        idx_write(32'hFFFE);
        data_op(1'b0, 2'd1, 32'h0, 0, "R8");
        idx_check("R8");

        check("R10", "bus idle at end", 32'(sram_req), 32'd0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10: watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule